// File: doc/BRIEF.md
# Reaction Timer with Two-Digit Decimal Display

The block measures the delay between an indicator lamp turning on and a person pressing a push-button. The system clock is divided by a power of two. With a 102.4 kHz clock and the default divider width of ten bits, this gives a 100 Hz counting rate. Each count is one hundredth of a second.

A one-cycle start pulse sets a single run flag. The run flag lights the lamp and lets a two-digit decimal counter advance once per divider tick. When the active-low button is pressed, it passes through a two-stage synchronizer and then clears the run flag. The count then freezes so it can be read. The count is shown as two decimal digits and as two seven-segment patterns.

The divider produces a one-cycle enable pulse, not a derived clock, so every register stays on the system clock. Once the count reaches 99 it stays at 99 until reset.

Top module: `reaction_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is as follows: `led` is 0, both digits are 0, the divider count is 0 and the synchronizer holds "released". Both segment outputs then show the pattern for 0, which is 7'h7E.
- R2: The divider counts the clock modulo 2^DIV_BITS, starting from 0 after reset. The tick is active in the cycle when the divider count is all ones. While running, the count advances by exactly one at each edge that has the tick active.
- R3: A high `start` at a rising edge drives `led` high from the next cycle.
- R4: A low level of `btn_n` that is sampled at edge k reaches the run flag at edge k+2. If `start` is low at that edge, `led` is low after edge k+2.
- R5: The count changes only at edges where `led` was high during the preceding cycle. While `led` is low, including when the button is pressed in the idle state, the digits hold.
- R6: Each digit is binary-coded decimal and stays in 0..9. When the units digit steps from 9, it goes to 0 and the tens digit advances in the same edge. The tens digit changes only in that case.
- R7: The count saturates: at 99, further ticks leave both digits at 9 until reset.
- R8: The segment outputs are active-high, with segment a at bit 6 down to segment g at bit 0. The patterns for 0 through 9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F and 7B (hex).
- R9: When `start` is high and the synchronized button is pressed at the same edge, `start` wins and `led` is high afterwards.
- R10: A `start` pulse during a run neither clears nor alters the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a measurement |
| btn_n | input | 1 | Push-button, low while pressed, asynchronous |
| led | output | 1 | Lamp drive, high while the measurement runs |
| units | output | 4 | Units digit in BCD |
| tens | output | 4 | Tens digit in BCD |
| seg_units | output | 7 | Seven-segment pattern of the units digit |
| seg_tens | output | 7 | Seven-segment pattern of the tens digit |

## Verification
A wrong divider phase shows up as a count step that lands on the wrong edge. This is visible within one tick period, because the reference model predicts the exact cycle of every step. A wrong run flag or synchronizer depth shows on `led` within two cycles of a start pulse or a button press. Any step of the count while `led` is low is also exposed in the next cycle. Errors in the digit carry or in saturation appear at the 9-to-10 rollover and at 99, both of which the stimulus reaches, so every such error is visible at the ports within a single cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    localparam bcd_t BCD_MAX = 4'd9;

    function automatic seg_t bcd_to_seg(input bcd_t v);
        seg_t s;
        case (v)
            4'd0:    s = 7'h7E;
            4'd1:    s = 7'h30;
            4'd2:    s = 7'h6D;
            4'd3:    s = 7'h79;
            4'd4:    s = 7'h33;
            4'd5:    s = 7'h5B;
            4'd6:    s = 7'h5F;
            4'd7:    s = 7'h70;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h7B;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rt_tick_div.sv
module rt_tick_div #(
    parameter int DIV_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [DIV_BITS-1:0] TERM = {DIV_BITS{1'b1}};

    typedef struct packed {
        logic [DIV_BITS-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick = (st_q.cnt == TERM);
endmodule

// File: rtl/rt_btn_sync.sv
module rt_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic pressed
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], btn_n};
        end else begin
            st_d.chain = btn_n;
        end
        if (rst) begin
            st_d.chain = '1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pressed = ~st_q.chain[STAGES-1];
endmodule

// File: rtl/rt_bcd_digit.sv
module rt_bcd_digit
    import rt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    output bcd_t value,
    output logic at_max
);
    typedef struct packed {
        bcd_t val;
    } dig_state_t;

    dig_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (st_q.val == BCD_MAX) begin
                st_d.val = '0;
            end else begin
                st_d.val = st_q.val + 4'd1;
            end
        end
        if (rst) begin
            st_d.val = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign value  = st_q.val;
    assign at_max = (st_q.val == BCD_MAX);
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
    import rt_pkg::*;
#(
    parameter int DIV_BITS    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       btn_n,
    output logic       led,
    output logic [3:0] units,
    output logic [3:0] tens,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens
);
    localparam int NDIG = 2;

    typedef struct packed {
        logic run;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic            tick;
    logic            pressed;
    logic [NDIG-1:0] dig_en;
    logic [NDIG-1:0] dig_max;
    bcd_t            dig_val [NDIG];
    seg_t            dig_seg [NDIG];
    logic            saturated;

    rt_tick_div #(.DIV_BITS(DIV_BITS)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rt_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .btn_n   (btn_n),
        .pressed (pressed)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.run = 1'b1;
        end else if (pressed) begin
            ctl_d.run = 1'b0;
        end
        if (rst) begin
            ctl_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign saturated = &dig_max;

    genvar gi;
    generate
        for (gi = 0; gi < NDIG; gi++) begin : g_digit
            if (gi == 0) begin : g_first
                assign dig_en[gi] = ctl_q.run & tick & ~saturated;
            end else begin : g_next
                assign dig_en[gi] = dig_en[gi-1] & dig_max[gi-1];
            end

            rt_bcd_digit u_digit (
                .clk    (clk),
                .rst    (rst),
                .en     (dig_en[gi]),
                .value  (dig_val[gi]),
                .at_max (dig_max[gi])
            );

            assign dig_seg[gi] = bcd_to_seg(dig_val[gi]);
        end
    endgenerate

    assign led       = ctl_q.run;
    assign units     = dig_val[0];
    assign tens      = dig_val[1];
    assign seg_units = dig_seg[0];
    assign seg_tens  = dig_seg[1];
endmodule

// File: rtl/reaction_timer_checker.sv
module reaction_timer_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       led,
    input logic [3:0] units,
    input logic [3:0] tens
);
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (units <= 4'd9) && (tens <= 4'd9)); // R6

    AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
        start |=> led); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !led |=> $stable({tens, units})); // R5

    AST_TENS_CARRY: assert property (@(posedge clk) disable iff (rst)
        !$stable(tens) |-> ($past(units) == 4'd9 && units == 4'd0)); // R6

    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        ({tens, units} == 8'h99) |=> ({tens, units} == 8'h99)); // R7
endmodule

bind reaction_timer reaction_timer_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .led   (led),
    .units (units),
    .tens  (tens)
);

// File: tb/reaction_timer_test.sv
module reaction_timer_test;
    localparam int DIVB   = 4;
    localparam int PERIOD = 1 << DIVB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic btn_n = 1'b1;
    logic       led;
    logic [3:0] units, tens;
    logic [6:0] seg_units, seg_tens;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int  m_div = 0;
    int  m_cnt = 0;
    bit  m_run = 0;
    bit  m_s1 = 1, m_s2 = 1;

    always #5 clk = ~clk;

    reaction_timer #(.DIV_BITS(DIVB)) uut (
        .clk(clk), .rst(rst), .start(start), .btn_n(btn_n),
        .led(led), .units(units), .tens(tens),
        .seg_units(seg_units), .seg_tens(seg_tens)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D;
            3: return 7'h79; 4: return 7'h33; 5: return 7'h5B;
            6: return 7'h5F; 7: return 7'h70; 8: return 7'h7F;
            9: return 7'h7B; default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit n_run;
        if (rst) begin
            m_div = 0; m_cnt = 0; m_run = 0; m_s1 = 1; m_s2 = 1;
        end else begin
            if (m_run && m_div == PERIOD - 1 && m_cnt < 99) m_cnt++;
            n_run = start ? 1'b1 : (!m_s2 ? 1'b0 : m_run);
            m_s2 = m_s1;
            m_s1 = btn_n;
            m_run = n_run;
            m_div = (m_div + 1) % PERIOD;
        end
    endtask

    // one cycle: edge, model, compare mid-cycle
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R3/R4 led", led, m_run);
        check("R2/R5 units", units, m_cnt % 10);
        check("R6 tens", tens, m_cnt / 10);
        check("R8 seg_units", seg_units, exp_seg(m_cnt % 10));
        check("R8 seg_tens", seg_tens, exp_seg(m_cnt / 10));
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        @(negedge clk);
        run_cycles(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 led after reset", led, 0);
        check("R1 units after reset", units, 0);
        check("R1 seg after reset", seg_units, 7'h7E);

        // R5 button pressed while idle: nothing changes
        btn_n = 1'b0;
        run_cycles(PERIOD * 3);
        check("R5 idle press holds count", {tens, units}, 0);
        btn_n = 1'b1;
        run_cycles(5);

        // R3 start and count, R2 tick spacing, R6 carry
        start = 1'b1; cyc(); start = 1'b0;
        check("R3 led after start", led, 1);
        run_cycles(PERIOD * 23 + 7);

        // R10 start during run keeps count
        start = 1'b1; cyc(); start = 1'b0;
        run_cycles(PERIOD * 2);

        // R4 press stops
        btn_n = 1'b0;
        run_cycles(4);
        check("R4 led low after press", led, 0);
        run_cycles(PERIOD * 4);
        check("R5 frozen count", units + 10 * tens, m_cnt);
        btn_n = 1'b1;
        run_cycles(6);

        // R9 start with pressed synchronized button
        btn_n = 1'b0;
        run_cycles(2);
        start = 1'b1; cyc(); start = 1'b0;
        check("R9 start wins", led, 1);
        btn_n = 1'b1;
        run_cycles(3);
        start = 1'b1; cyc(); start = 1'b0;

        // R7 saturate
        run_cycles(PERIOD * 105);
        check("R7 saturated units", units, 9);
        check("R7 saturated tens", tens, 9);
        run_cycles(PERIOD * 3);
        check("R7 still 99", {tens, units}, 8'h99);

        // R1 reset clears mid-run
        rst = 1'b1; cyc(); rst = 1'b0;
        check("R1 reset clears led", led, 0);
        check("R1 reset clears count", {tens, units}, 0);

        // second short run from fresh state, R2 first step timing
        start = 1'b1; cyc(); start = 1'b0;
        run_cycles(PERIOD * 12);
        btn_n = 1'b0;
        run_cycles(6);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule